// File: doc/BRIEF.md
# Lockable Watchdog Timer

A memory-mapped watchdog counter for a processor subsystem. Software programs a reload value and sets the run bit in the control register. From then on the counter counts down once per clock. When the counter expires, the block raises a pending time-out flag and restarts from the reload value. If the counter expires again while that flag is still pending, the block requests a system reset, provided reset generation is enabled. Software keeps the system alive by clearing the pending flag before the second expiry.

The configuration registers (reload and control) can be write-protected. Any write to the protection register engages the protection, except a write of the single release key. A test register holds a freeze bit. While that bit is set, a debug-halt input stops the counter, so the timer does not expire while a debugger has stopped the processor.

The register interface is a single-cycle write strobe with a word address and write data. Read data is combinational from the address.

Top module: `wdog_lockable`

## Requirements
- R1: After reset, word 0 (reload) reads 0xFFFFFFFF and word 1 (count) reads 0xFFFFFFFF. Word 2 (control), word 3 (raw flag), word 4 (masked flag) and word 6 (protection) read 0. irqOut and rstReq are low.
- R2: While control bit 0 (run) is set, the count in word 1 drops by one on each clock.
- R3: On a clock where the running count is zero, word 3 bit 0 becomes 1 and the count restarts from the reload value. The period is therefore reload+1 clocks.
- R4: If the count expires while word 3 bit 0 is already 1 and control bit 1 (reset enable) is set, rstReq is high for exactly one cycle. If control bit 1 is clear, rstReq stays low.
- R5: Word 4 bit 0 reads the raw flag ANDed with the run bit, and irqOut equals that value.
- R6: A write to word 5 with bit 0 set clears the raw flag. If an expiry happens on the same clock, the flag stays set.
- R7: A write to word 6 of any value other than 0x1ACCE551 makes word 6 read 1 (protected). A write of 0x1ACCE551 makes it read 0.
- R8: While protected, writes to word 0 and word 2 change nothing.
- R9: An accepted write to word 0 puts the value into the count on the same clock. A written value of zero sets the raw flag on that clock.
- R10: Once set, the run bit can only be cleared by reset. A write of 0 to control bit 0 leaves it at 1.
- R11: With word 7 bit 0 (freeze) set and dbgHalt high, the count holds. With freeze clear, dbgHalt has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr |
| dbgHalt | input | 1 | Processor halted by debugger |
| irqOut | output | 1 | Masked time-out interrupt |
| rstReq | output | 1 | One-cycle system reset request |

## Verification
A time-out and a software clear of the pending flag can both happen on the same clock. They compete for the same flag bit. The bench provokes this by counting clocks from the run-bit write and placing the clear write exactly on the reload edge. It then reads word 3: the flag must still be 1, since a clear that wins would hide a real expiry. The count must also have restarted at the reload value.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_RELOAD = 3'd0,
    REG_COUNT  = 3'd1,
    REG_CTRL   = 3'd2,
    REG_RAW    = 3'd3,
    REG_MASKED = 3'd4,
    REG_CLEAR  = 3'd5,
    REG_GUARD  = 3'd6,
    REG_TEST   = 3'd7
  } wdog_reg_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWr;   // accepted reload write
    logic clrIrq;   // clear pending flag
    logic run;      // counter may advance this cycle
  } wdog_strb_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] LOAD_RESET = '1,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dbgHalt,
  input  logic [DATA_W-1:0] cntVal,
  input  logic              rawIrq,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] loadReg,
  output logic              irqEn,
  output logic              rstEn,
  output logic              stallEn,
  output logic              locked,
  output wdog_strb_t        strb
);
  logic selLoad, selCtrl, selClear, selGuard, selTest;

  always_comb begin
    selLoad  = wrEn && (addr == REG_RELOAD);
    selCtrl  = wrEn && (addr == REG_CTRL);
    selClear = wrEn && (addr == REG_CLEAR);
    selGuard = wrEn && (addr == REG_GUARD);
    selTest  = wrEn && (addr == REG_TEST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadReg <= LOAD_RESET;
      irqEn   <= 1'b0;
      rstEn   <= 1'b0;
      stallEn <= 1'b0;
      locked  <= 1'b0;
    end else begin
      if (selLoad && !locked) loadReg <= wrData;
      if (selCtrl && !locked) begin
        irqEn <= irqEn | wrData[0];   // sticky until reset
        rstEn <= wrData[1];
      end
      if (selTest)  stallEn <= wrData[0];
      if (selGuard) locked  <= (wrData != UNLOCK_KEY);
    end
  end

  always_comb begin
    strb.loadWr = selLoad && !locked;
    strb.clrIrq = selClear && wrData[0];
    strb.run    = irqEn && !(stallEn && dbgHalt);
  end

  always_comb begin
    rdData = '0;
    case (addr)
      REG_RELOAD: rdData = loadReg;
      REG_COUNT:  rdData = cntVal;
      REG_CTRL:   rdData = DATA_W'({rstEn, irqEn});
      REG_RAW:    rdData = DATA_W'(rawIrq);
      REG_MASKED: rdData = DATA_W'(rawIrq && irqEn);
      REG_GUARD:  rdData = DATA_W'(locked);
      REG_TEST:   rdData = DATA_W'(stallEn);
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] LOAD_RESET = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdog_strb_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] loadReg,
  input  logic              rstEn,
  output logic [DATA_W-1:0] cntVal,
  output logic              rawIrq,
  output logic              rstReq
);
  logic expire;
  assign expire = strb.run && !strb.loadWr && (cntVal == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= LOAD_RESET;
      rawIrq <= 1'b0;
      rstReq <= 1'b0;
    end else begin
      rstReq <= expire && rawIrq && rstEn;
      if (strb.clrIrq) rawIrq <= 1'b0;
      if (strb.loadWr) begin
        cntVal <= wrData;
        if (wrData == '0) rawIrq <= 1'b1;
      end else if (strb.run) begin
        if (expire) begin
          cntVal <= loadReg;
          rawIrq <= 1'b1;     // set wins over a same-cycle clear
        end else begin
          cntVal <= cntVal - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_lockable.sv
module wdog_lockable
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] LOAD_RESET = '1,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              dbgHalt,
  output logic              irqOut,
  output logic              rstReq
);
  wdog_strb_t        strb;
  logic [DATA_W-1:0] cntVal, loadReg;
  logic              rawIrq, irqEn, rstEn, stallEn, locked;

  wdog_ctrl #(.DATA_W(DATA_W), .LOAD_RESET(LOAD_RESET), .UNLOCK_KEY(UNLOCK_KEY)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .dbgHalt(dbgHalt), .cntVal(cntVal), .rawIrq(rawIrq), .rdData(rdData),
    .loadReg(loadReg), .irqEn(irqEn), .rstEn(rstEn), .stallEn(stallEn),
    .locked(locked), .strb(strb)
  );

  wdog_datapath #(.DATA_W(DATA_W), .LOAD_RESET(LOAD_RESET)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .loadReg(loadReg),
    .rstEn(rstEn), .cntVal(cntVal), .rawIrq(rawIrq), .rstReq(rstReq)
  );

  assign irqOut = rawIrq && irqEn;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic              dbgHalt,
  input logic              rstReq,
  input logic [DATA_W-1:0] cntVal,
  input logic [DATA_W-1:0] loadReg,
  input logic              rawIrq,
  input logic              irqEn,
  input logic              rstEn,
  input logic              stallEn,
  input logic              locked
);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  a_r4_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> ($past(rawIrq) && $past(rstEn)));

  a_r3_expiry_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    (irqEn && !(stallEn && dbgHalt) && cntVal == '0 && !(wrEn && addr == REG_RELOAD))
      |=> rawIrq);

  a_r8_locked_reload: assert property (@(posedge clk) disable iff (!rstN)
    (locked && wrEn && addr == REG_RELOAD) |=> $stable(loadReg));

  a_r10_run_sticky: assert property (@(posedge clk) disable iff (!rstN)
    irqEn |=> irqEn);

  a_r11_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (stallEn && dbgHalt && !(wrEn && addr == REG_RELOAD)) |=> $stable(cntVal));
endmodule

bind wdog_lockable wdog_checker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .dbgHalt(dbgHalt),
  .rstReq(rstReq), .cntVal(cntVal), .loadReg(loadReg), .rawIrq(rawIrq),
  .irqEn(irqEn), .rstEn(rstEn), .stallEn(stallEn), .locked(locked)
);

// File: tb/tb_wdog_lockable.sv
module tb_wdog_lockable;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        dbgHalt = 1'b0;
  logic        irqOut, rstReq;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  wdog_lockable dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .dbgHalt(dbgHalt), .irqOut(irqOut), .rstReq(rstReq));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // caller is at a negedge; returns at the next negedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic doReset();
    rstN = 1'b0; dbgHalt = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    logic [31:0] v;
    doReset();
    rd(0, v); chk("R1 reload", v, 32'hFFFF_FFFF);
    rd(1, v); chk("R1 count", v, 32'hFFFF_FFFF);
    rd(2, v); chk("R1 ctrl", v, 0);
    rd(3, v); chk("R1 raw", v, 0);
    rd(6, v); chk("R1 guard", v, 0);
    chk("R1 irqOut", irqOut, 0);
    chk("R1 rstReq", rstReq, 0);
  endtask

  task automatic testCountdown();
    logic [31:0] v;
    doReset();
    wr(0, 5); wr(2, 1);
    for (int i = 0; i < 6; i++) begin
      rd(1, v); chk("R2 count", v, 5 - i);
      @(negedge clk);
    end
    rd(1, v); chk("R3 reload", v, 5);
    rd(3, v); chk("R3 raw", v, 1);
    rd(4, v); chk("R5 masked", v, 1);
    chk("R5 irqOut", irqOut, 1);
  endtask

  task automatic testResetReq(input bit en);
    logic [31:0] v;
    doReset();
    wr(0, 5); wr(2, en ? 3 : 1);
    repeat (11) @(negedge clk);
    chk("R4 before", rstReq, 0);
    @(negedge clk);
    chk(en ? "R4 pulse" : "R4 disabled", rstReq, en);
    @(negedge clk);
    chk("R4 one cycle", rstReq, 0);
    rd(3, v); chk("R4 raw held", v, 1);
  endtask

  task automatic testClearRace();
    logic [31:0] v;
    doReset();
    wr(0, 3); wr(2, 1);
    repeat (3) @(negedge clk);
    wr(5, 1);                       // lands on the expiry edge
    rd(3, v); chk("R6 set wins", v, 1);
    rd(1, v); chk("R6 reloaded", v, 3);
    wr(5, 1);
    rd(3, v); chk("R6 clear", v, 0);
    chk("R6 irqOut low", irqOut, 0);
  endtask

  task automatic testLock();
    logic [31:0] v;
    doReset();
    wr(6, 0);
    rd(6, v); chk("R7 locked", v, 1);
    wr(0, 7);
    rd(0, v); chk("R8 reload ignored", v, 32'hFFFF_FFFF);
    wr(2, 3);
    rd(2, v); chk("R8 ctrl ignored", v, 0);
    @(negedge clk);
    rd(1, v); chk("R8 not running", v, 32'hFFFF_FFFF);
    wr(6, 32'h1ACC_E550);
    rd(6, v); chk("R7 wrong key", v, 1);
    wr(6, 32'h1ACC_E551);
    rd(6, v); chk("R7 unlocked", v, 0);
    wr(0, 7);
    rd(0, v); chk("R7 reload accepted", v, 7);
  endtask

  task automatic testLiveLoad();
    logic [31:0] v;
    doReset();
    wr(0, 50); wr(2, 1);
    repeat (3) @(negedge clk);
    wr(0, 20);
    rd(1, v); chk("R9 immediate", v, 20);
    @(negedge clk);
    rd(1, v); chk("R9 continues", v, 19);
  endtask

  task automatic testZeroAndSticky();
    logic [31:0] v;
    doReset();
    wr(0, 0);
    rd(3, v); chk("R9 zero sets raw", v, 1);
    rd(4, v); chk("R5 masked off", v, 0);
    chk("R5 irqOut off", irqOut, 0);
    wr(2, 1);
    chk("R5 irqOut on", irqOut, 1);
    wr(2, 0);
    rd(2, v); chk("R10 sticky", v, 1);
  endtask

  task automatic testStall();
    logic [31:0] v0, v;
    doReset();
    wr(7, 1); wr(0, 100); wr(2, 1);
    dbgHalt = 1'b1;
    @(negedge clk);
    rd(1, v0);
    repeat (4) @(negedge clk);
    rd(1, v); chk("R11 frozen", v, v0);
    dbgHalt = 1'b0;
    @(negedge clk);
    rd(1, v); chk("R11 resumes", v, v0 - 1);
    wr(7, 0);
    dbgHalt = 1'b1;
    rd(1, v0);
    @(negedge clk);
    rd(1, v); chk("R11 freeze off", v, v0 - 1);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testCountdown();
    testResetReq(1);
    testResetReq(0);
    testClearRace();
    testLock();
    testLiveLoad();
    testZeroAndSticky();
    testStall();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule